// File: doc/BRIEF.md
# Page Table Walker for Translation Misses

This block services a miss in the translation buffer by fetching one page table entry from memory. When the buffer reports a missing virtual page number, the walker accepts it, computes where the matching entry lives, and issues one memory read. The computation adds the current table base to the virtual page number scaled by the four-byte entry size. No tag compare is involved, because the table is indexed directly by the virtual page number. The returned entry either yields a physical page number to refill the buffer, or its cleared valid bit turns the miss into a page fault. The fault is held until software acknowledges it.

The table base sits in a software-writable register, because each process owns its own table. A base update that arrives while a walk is in flight is parked and applied as the walk finishes. The walk in progress therefore always uses one consistent base.

The controller has five named states. IDLE takes a miss (IDLE→READ). READ drives the read request for one cycle (READ→WAIT). WAIT holds until read data is valid: WAIT→REFILL when the valid bit is set, WAIT→FAULT when it is clear. REFILL presents the translation for one cycle (REFILL→IDLE). FAULT holds until acknowledged (FAULT→IDLE).

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is in IDLE with no read request, no refill and no fault, and the table base is zero.
- R2: A miss is accepted only in IDLE; `miss_ack` is high in the same cycle as `miss_req` then, and stays low for any request made while a walk is busy.
- R3: One cycle after acceptance, `mem_rd_req` is high for exactly one cycle with `mem_rd_addr` = base + 4 × VPN, wrapping modulo 2^32.
- R4: The walker waits any number of cycles in WAIT for `mem_rd_valid`; a `mem_rd_valid` outside WAIT has no effect.
- R5: An entry with bit 31 set gives `refill_valid` for exactly one cycle, one cycle after the data is taken, with `refill_vpn` = the missed VPN and `refill_ppn` = entry bits 17:0; all other entry bits are ignored.
- R6: An entry with bit 31 clear raises `fault_valid` with `fault_vpn`, held stable until `fault_ack` is high on a clock edge; the walker is back in IDLE on the next cycle.
- R7: A base write in IDLE takes effect at the next clock edge; a miss accepted in the same cycle still uses the previous base.
- R8: Base writes made during a walk do not touch the base in use; the latest one is applied when the walk finishes (leaving REFILL, or FAULT on acknowledge), including a write in that same final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Translation miss request |
| miss_vpn | input | 20 | Virtual page number that missed |
| miss_ack | output | 1 | Miss accepted this cycle |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | 32 | New table base address |
| mem_rd_req | output | 1 | Entry read request (one-cycle pulse) |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Fetched page table entry |
| refill_valid | output | 1 | Translation ready for refill |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_ppn | output | 18 | Physical page number of the refill |
| fault_valid | output | 1 | Page fault pending |
| fault_vpn | output | 20 | Virtual page number that faulted |
| fault_ack | input | 1 | Fault acknowledge |

## Verification
Two functions can land in the same cycle: a base write and a miss acceptance in IDLE, or a base write and the final cycle of a walk. The bench drives the write strobe together with `miss_req`, and judges the result by the read address. That address must use the old base, and the following walk must use the new one. The bench also pulses `fault_ack` together with a base write in FAULT, and queues two writes during WAIT. It then confirms through the next walk's address that the newest value won.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_REFILL,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              busy,
    input  logic              walk_done,
    output logic [ADDR_W-1:0] base_q
);
    logic              pend_q;
    logic [ADDR_W-1:0] pend_data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else if (wr_en && !busy) begin
            base_q <= wr_data;
        end else if (walk_done) begin
            // newest write wins: same-cycle write beats a parked one
            if (wr_en) begin
                base_q <= wr_data;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                base_q <= pend_data_q;
                pend_q <= 1'b0;
            end
        end else if (wr_en) begin
            pend_q      <= 1'b1;
            pend_data_q <= wr_data;
        end
    end

    // R7
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> (base_q == $past(wr_data)));

    // R8
    busy_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !walk_done) |=> $stable(base_q));
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int VPN_W       = 20,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int OFF_SHIFT = $clog2(ENTRY_BYTES);

    always_comb begin
        entry_addr = base + (ADDR_W'(vpn) << OFF_SHIFT);
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 18,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              miss_ack,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              refill_valid,
    output logic [VPN_W-1:0]  refill_vpn,
    output logic [PPN_W-1:0]  refill_ppn,
    output logic              fault_valid,
    output logic [VPN_W-1:0]  fault_vpn,
    input  logic              fault_ack,
    output logic              busy,
    output logic              walk_done
);
    walk_state_e       state_q, state_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PPN_W-1:0]  ppn_q;
    logic              take_data;
    logic              unused_pte_bits;

    assign take_data       = (state_q == ST_WAIT) && mem_rd_valid;
    assign unused_pte_bits = ^mem_rd_data;

    // state and capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            addr_q  <= '0;
            ppn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (miss_ack) begin
                vpn_q  <= miss_vpn;
                addr_q <= entry_addr;
            end
            if (take_data) begin
                ppn_q <= mem_rd_data[PPN_W-1:0];
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (miss_req) state_d = ST_READ;
            ST_READ:   state_d = ST_WAIT;
            ST_WAIT:   if (mem_rd_valid)
                           state_d = mem_rd_data[VALID_BIT] ? ST_REFILL : ST_FAULT;
            ST_REFILL: state_d = ST_IDLE;
            ST_FAULT:  if (fault_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        miss_ack     = 1'b0;
        mem_rd_req   = 1'b0;
        refill_valid = 1'b0;
        fault_valid  = 1'b0;
        walk_done    = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                miss_ack = miss_req;
            end
            ST_READ:   mem_rd_req = 1'b1;
            ST_WAIT:   ;
            ST_REFILL: begin
                refill_valid = 1'b1;
                walk_done    = 1'b1;
            end
            ST_FAULT: begin
                fault_valid = 1'b1;
                walk_done   = fault_ack;
            end
            default: ;
        endcase
    end

    assign mem_rd_addr = addr_q;
    assign refill_vpn  = vpn_q;
    assign refill_ppn  = ppn_q;
    assign fault_vpn   = vpn_q;

    // R3
    rd_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ack |=> (mem_rd_req && mem_rd_addr == $past(entry_addr)));

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !mem_rd_valid) |=> (state_q == ST_WAIT));

    // R5
    refill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |=> (!refill_valid && !busy));

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_vpn)));

    // R6
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_ack) |=> !busy);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int ADDR_W      = 32,
    parameter int VPN_W       = 20,
    parameter int PPN_W       = 18,
    parameter int PTE_W       = 32,
    parameter int ENTRY_BYTES = 4,
    parameter int VALID_BIT   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic              miss_ack,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              refill_valid,
    output logic [VPN_W-1:0]  refill_vpn,
    output logic [PPN_W-1:0]  refill_ppn,
    output logic              fault_valid,
    output logic [VPN_W-1:0]  fault_vpn,
    input  logic              fault_ack
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] entry_addr;
    logic              busy;
    logic              walk_done;

    pt_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (base_wr_en),
        .wr_data   (base_wr_data),
        .busy      (busy),
        .walk_done (walk_done),
        .base_q    (base_q)
    );

    pt_addr_gen #(
        .ADDR_W      (ADDR_W),
        .VPN_W       (VPN_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_addr (
        .base       (base_q),
        .vpn        (miss_vpn),
        .entry_addr (entry_addr)
    );

    pt_walk_fsm #(
        .ADDR_W    (ADDR_W),
        .VPN_W     (VPN_W),
        .PPN_W     (PPN_W),
        .PTE_W     (PTE_W),
        .VALID_BIT (VALID_BIT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_req     (miss_req),
        .miss_vpn     (miss_vpn),
        .entry_addr   (entry_addr),
        .miss_ack     (miss_ack),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .refill_valid (refill_valid),
        .refill_vpn   (refill_vpn),
        .refill_ppn   (refill_ppn),
        .fault_valid  (fault_valid),
        .fault_vpn    (fault_vpn),
        .fault_ack    (fault_ack),
        .busy         (busy),
        .walk_done    (walk_done)
    );
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_req = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic        miss_ack;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [17:0] refill_ppn;
    logic        fault_valid;
    logic [19:0] fault_vpn;
    logic        fault_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_req(miss_req), .miss_vpn(miss_vpn), .miss_ack(miss_ack),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .fault_valid(fault_valid), .fault_vpn(fault_vpn), .fault_ack(fault_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // accept a miss (optionally with a same-cycle base write) and check the read pulse
    task automatic start(input logic [19:0] vpn, input logic [31:0] exp_addr,
                         input bit wr, input logic [31:0] wdata);
        @(negedge clk);
        miss_req = 1'b1; miss_vpn = vpn;
        base_wr_en = wr; base_wr_data = wdata;
        #1 chk("R2 miss_ack in IDLE", 32'(miss_ack), 32'd1);
        @(negedge clk);
        miss_req = 1'b0; base_wr_en = 1'b0;
        chk("R3 read pulse", 32'(mem_rd_req), 32'd1);
        chk("R3 entry address", mem_rd_addr, exp_addr);
    endtask

    // answer the read after lat idle cycles in WAIT
    task automatic respond(input int lat, input logic [31:0] pte);
        @(negedge clk);
        chk("R3 read is one cycle", 32'(mem_rd_req), 32'd0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R4 no result while waiting", 32'(refill_valid | fault_valid), 32'd0);
        end
        mem_rd_valid = 1'b1; mem_rd_data = pte;
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_data = '0;
    endtask

    task automatic expect_refill(input logic [19:0] vpn, input logic [17:0] ppn);
        chk("R5 refill_valid", 32'(refill_valid), 32'd1);
        chk("R5 refill_vpn", 32'(refill_vpn), 32'(vpn));
        chk("R5 refill_ppn", 32'(refill_ppn), 32'(ppn));
        chk("R5 no fault", 32'(fault_valid), 32'd0);
        @(negedge clk);
        chk("R5 refill one cycle", 32'(refill_valid), 32'd0);
    endtask

    task automatic base_write(input logic [31:0] v);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = v;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 no read after reset", 32'(mem_rd_req), 32'd0);
        chk("R1 no refill after reset", 32'(refill_valid), 32'd0);
        chk("R1 no fault after reset", 32'(fault_valid), 32'd0);
        // R1: base is zero, so vpn 5 reads address 0x14
        start(20'd5, 32'h14, 1'b0, '0);
        respond(0, 32'hFFFC_1234);
        expect_refill(20'd5, 18'h01234);
    endtask

    task automatic test_latency_and_wrap();
        base_write(32'h1000_0000);
        start(20'hFFFFF, 32'h103F_FFFC, 1'b0, '0);
        respond(7, 32'h8003_FFFF);
        expect_refill(20'hFFFFF, 18'h3FFFF);
        base_write(32'hFFFF_FFF0);
        start(20'd8, 32'h0000_0010, 1'b0, '0);   // R3 wraps modulo 2^32
        respond(2, 32'h8000_0000);
        expect_refill(20'd8, 18'h0);
    endtask

    task automatic test_stray_valid();
        // R4: valid in IDLE is ignored
        @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = 32'h8000_0001;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk("R4 stray valid ignored", 32'(refill_valid | fault_valid | mem_rd_req), 32'd0);
    endtask

    task automatic test_fault_and_busy();
        base_write(32'h0000_4000);
        start(20'h00ABC, 32'h0000_6AF0, 1'b0, '0);
        @(negedge clk);                          // now in WAIT
        miss_req = 1'b1; miss_vpn = 20'h11111;
        #1 chk("R2 no ack while busy", 32'(miss_ack), 32'd0);
        @(negedge clk);
        miss_req = 1'b0;
        mem_rd_valid = 1'b1; mem_rd_data = 32'h7FFF_FFFF;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R6 fault held", 32'(fault_valid), 32'd1);
            chk("R6 fault_vpn", 32'(fault_vpn), 32'h00ABC);
            chk("R6 no refill on fault", 32'(refill_valid), 32'd0);
            @(negedge clk);
        end
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        chk("R6 fault released", 32'(fault_valid), 32'd0);
        miss_req = 1'b1; miss_vpn = 20'd1;
        #1 chk("R6 idle after ack", 32'(miss_ack), 32'd1);
        @(negedge clk);
        miss_req = 1'b0;
        respond(0, 32'h8000_0007);
        expect_refill(20'd1, 18'd7);
    endtask

    task automatic test_base_collisions();
        // R7: same-cycle write and miss uses the old base 0x4000
        start(20'd2, 32'h0000_4008, 1'b1, 32'h0002_0000);
        respond(0, 32'h8000_0002);
        expect_refill(20'd2, 18'd2);
        start(20'd2, 32'h0002_0008, 1'b0, '0);  // R7 new base next walk
        @(negedge clk);                          // WAIT: park two writes
        base_wr_en = 1'b1; base_wr_data = 32'h0003_0000;
        @(negedge clk);
        base_wr_data = 32'h0005_0000;
        @(negedge clk);
        base_wr_en = 1'b0;
        mem_rd_valid = 1'b1; mem_rd_data = 32'h0;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk("R6 fault on clear valid", 32'(fault_valid), 32'd1);
        @(negedge clk);
        // R8: write together with ack overrides the parked value
        fault_ack = 1'b1; base_wr_en = 1'b1; base_wr_data = 32'h0007_0000;
        @(negedge clk);
        fault_ack = 1'b0; base_wr_en = 1'b0;
        start(20'd3, 32'h0007_000C, 1'b0, '0);
        respond(1, 32'h8000_0003);
        expect_refill(20'd3, 18'd3);
        // R8: parked write alone applied after a refill
        start(20'd4, 32'h0007_0010, 1'b0, '0);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 32'h0009_0000;
        @(negedge clk);
        base_wr_en = 1'b0;
        mem_rd_valid = 1'b1; mem_rd_data = 32'h8000_0004;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        expect_refill(20'd4, 18'd4);
        start(20'd1, 32'h0009_0004, 1'b0, '0);
        respond(0, 32'h8000_0009);
        expect_refill(20'd1, 18'd9);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_latency_and_wrap();
        test_stray_valid();
        test_fault_and_busy();
        test_base_collisions();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule